// File: doc/BRIEF.md
# Bidirectional Port with Strobe-Latched Input

An eight-bit general-purpose peripheral port. Each bit has a direction bit that makes the pin an input (0) or an output (1), and an output-register bit that sets the level of an output pin. The processor reads the port through a byte-wide register interface. Output bits read back the output register. Input bits return either the live pin levels or a snapshot that was taken when the strobe line made its active transition.

A strobe input feeds a two-state edge tracker. Its states are `LVL_LOW` and `LVL_HIGH`. The transition `LVL_LOW -> LVL_HIGH` is the rise event and `LVL_HIGH -> LVL_LOW` is the fall event. A state with no change holds. One configuration input picks which event counts as active. An active event sets a strobe interrupt flag. When latch mode is enabled, the same event also captures the pins into the snapshot register.

The data register appears at two addresses. Access through offset 0x1 is a handshake access and clears the flag. Access through offset 0xF does the same read or write but leaves the flag alone. The direction register sits at offset 0x3. Any other offset reads zero and ignores writes.

Top module: `strobe_port`

## Requirements
- R1: After reset, pin_oe, pin_out and strobe_flag are 0, the direction, output and snapshot registers are zero, and a read at offset 0x1 returns pin_in.
- R2: A write at offset 0x3 stores the direction register. pin_oe equals that register from the next cycle on, and a read at offset 0x3 returns it.
- R3: For each bit, pin_out is the output-register bit when the direction bit is 1 and 0 when it is 0. A write at offset 0x1 or 0xF stores all eight output bits, and bits stored while their pin is an input appear on pin_out once the direction bit is set.
- R4: A read at offset 0x1 or 0xF returns the output-register bit for output bits. With cfg_latch_en = 0 it returns the current pin_in level for input bits.
- R5: The strobe input is registered. A change present at rising edge E0 is an event between E0 and E1. If the event is active, strobe_flag is 1 after E1.
- R6: With cfg_latch_en = 1, an active event at E1 captures pin_in into the snapshot. Input bits then read the snapshot, and later pin changes have no effect until the next active event.
- R7: A read or write at offset 0x1 clears strobe_flag at that clock edge. The same access at offset 0xF leaves the flag unchanged.
- R8: With cfg_rise_edge = 1 only low-to-high strobe changes are active. With cfg_rise_edge = 0 only high-to-low changes are active. The inactive direction neither sets the flag nor captures.
- R9: When an active event and a clearing access at offset 0x1 fall on the same edge, strobe_flag is 1 after that edge.
- R10: With cfg_latch_en = 0, active events still set the flag but leave the snapshot unchanged. Setting cfg_latch_en back to 1 reads the earlier snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle (used for flag clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 8 | External pin levels |
| pin_out | output | 8 | Driven pin levels, zero for input bits |
| pin_oe | output | 8 | Per-bit output enable |
| strobe_in | input | 1 | Strobe line |
| cfg_latch_en | input | 1 | 1 selects snapshot reads and capture |
| cfg_rise_edge | input | 1 | 1 makes rising strobe changes active, 0 falling |
| strobe_flag | output | 1 | Strobe interrupt flag |

## Verification
The bench checks that a strobe change raises the flag exactly on the second clock edge, not the first. It also checks that an inactive edge direction does nothing, since an edge tracker with the wrong polarity would set the flag on the wrong transition. It then pits a handshake clear against an active event on the same edge: a design that lets the clear win would lose the event. Finally it checks that the 0xF alias keeps the flag, that snapshot data survives both later pin changes and a period with latching off, and that output bits written while they were inputs surface only when their direction bit is set.

// File: rtl/sport_pkg.sv
package sport_pkg;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_DATA_HS  = 2'd1,
        ACC_DATA_QT  = 2'd2,
        ACC_DIR      = 2'd3
    } acc_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } strobe_lvl_e;

endpackage

// File: rtl/sport_decode.sv
module sport_decode
    import sport_pkg::*;
#(
    parameter int              AW      = 4,
    parameter logic [AW-1:0]   OFS_HS  = 'h1,
    parameter logic [AW-1:0]   OFS_QT  = 'hF,
    parameter logic [AW-1:0]   OFS_DIR = 'h3
) (
    input  logic [AW-1:0] addr,
    output acc_e          sel
);

    always_comb begin
        sel = ACC_NONE;
        if (addr == OFS_HS)       sel = ACC_DATA_HS;
        else if (addr == OFS_QT)  sel = ACC_DATA_QT;
        else if (addr == OFS_DIR) sel = ACC_DIR;
    end

endmodule

// File: rtl/sport_strobe_fsm.sv
module sport_strobe_fsm
    import sport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    input  logic rise_sel,
    output logic edge_hit
);

    logic        strobe_s;
    strobe_lvl_e state_q;
    strobe_lvl_e state_d;

    // input register: the transition becomes visible one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_s <= 1'b0;
        else        strobe_s <= strobe_in;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (strobe_s)  state_d = LVL_HIGH;
            LVL_HIGH: if (!strobe_s) state_d = LVL_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        edge_hit = 1'b0;
        unique case (state_q)
            LVL_LOW:  edge_hit = strobe_s && rise_sel;
            LVL_HIGH: edge_hit = !strobe_s && !rise_sel;
        endcase
    end

endmodule

// File: rtl/sport_latch.sv
module sport_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] snap_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       snap_q <= '0;
        else if (capture) snap_q <= pin_in;
    end

endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  acc_e         sel,
    input  logic         wr,
    input  logic         rd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    input  logic [W-1:0] snap_q,
    input  logic         use_snap,
    input  logic         edge_hit,
    output logic [W-1:0] rdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q,
    output logic         flag_q
);

    logic [W-1:0] port_view;
    logic         hs_touch;

    assign hs_touch = (rd || wr) && (sel == ACC_DATA_HS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (wr) begin
            if (sel == ACC_DIR) dir_q <= wdata;
            if (sel == ACC_DATA_HS || sel == ACC_DATA_QT) out_q <= wdata;
        end
    end

    // an event on the same edge as a handshake clear keeps the flag set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (edge_hit) flag_q <= 1'b1;
        else if (hs_touch) flag_q <= 1'b0;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign port_view[i] = dir_q[i] ? out_q[i]
                                       : (use_snap ? snap_q[i] : pin_in[i]);
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            ACC_DATA_HS, ACC_DATA_QT: rdata = port_view;
            ACC_DIR:                  rdata = dir_q;
            ACC_NONE:                 rdata = '0;
        endcase
    end

endmodule

// File: rtl/strobe_port.sv
module strobe_port
    import sport_pkg::*;
#(
    parameter int              W       = 8,
    parameter int              AW      = 4,
    parameter logic [AW-1:0]   OFS_HS  = 'h1,
    parameter logic [AW-1:0]   OFS_QT  = 'hF,
    parameter logic [AW-1:0]   OFS_DIR = 'h3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    input  logic          strobe_in,
    input  logic          cfg_latch_en,
    input  logic          cfg_rise_edge,
    output logic          strobe_flag
);

    acc_e         sel;
    logic         edge_hit;
    logic [W-1:0] snap_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] out_q;

    sport_decode #(
        .AW(AW), .OFS_HS(OFS_HS), .OFS_QT(OFS_QT), .OFS_DIR(OFS_DIR)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    sport_strobe_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (strobe_in),
        .rise_sel  (cfg_rise_edge),
        .edge_hit  (edge_hit)
    );

    sport_latch #(.W(W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (edge_hit && cfg_latch_en),
        .pin_in  (pin_in),
        .snap_q  (snap_q)
    );

    sport_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .pin_in   (pin_in),
        .snap_q   (snap_q),
        .use_snap (cfg_latch_en),
        .edge_hit (edge_hit),
        .rdata    (bus_rdata),
        .dir_q    (dir_q),
        .out_q    (out_q),
        .flag_q   (strobe_flag)
    );

    assign pin_oe  = dir_q;
    assign pin_out = out_q & dir_q;

endmodule

// File: rtl/strobe_port_chk.sv
module strobe_port_chk #(
    parameter int              W       = 8,
    parameter int              AW      = 4,
    parameter logic [AW-1:0]   OFS_HS  = 'h1,
    parameter logic [AW-1:0]   OFS_QT  = 'hF,
    parameter logic [AW-1:0]   OFS_DIR = 'h3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  pin_out,
    input logic [W-1:0]  pin_oe,
    input logic          strobe_in,
    input logic          cfg_rise_edge,
    input logic          strobe_flag
);

    // R2
    a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R3
    a_r3_input_bits_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == '0));

    // R3
    a_r3_data_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_HS || bus_addr == OFS_QT))
        |=> (pin_out == ($past(bus_wdata) & pin_oe)));

    // R5, R8
    a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rise_edge && $past(strobe_in) && !$past(strobe_in, 2)) |=> strobe_flag);

    // R8
    a_r8_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_rise_edge && !$past(strobe_in) && $past(strobe_in, 2)) |=> strobe_flag);

    // R7
    a_r7_alias_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_flag && (bus_rd || bus_wr) && bus_addr == OFS_QT) |=> strobe_flag);

    // R7
    a_r7_hs_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr == OFS_HS
         && ($past(strobe_in) == $past(strobe_in, 2))) |=> !strobe_flag);

endmodule

bind strobe_port strobe_port_chk #(
    .W(W), .AW(AW), .OFS_HS(OFS_HS), .OFS_QT(OFS_QT), .OFS_DIR(OFS_DIR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_wdata     (bus_wdata),
    .pin_out       (pin_out),
    .pin_oe        (pin_oe),
    .strobe_in     (strobe_in),
    .cfg_rise_edge (cfg_rise_edge),
    .strobe_flag   (strobe_flag)
);

// File: tb/strobe_port_bench.sv
`timescale 1ns/100ps
module strobe_port_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'hA5;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic       strobe_in = 1'b0;
    logic       cfg_latch_en = 1'b0;
    logic       cfg_rise_edge = 1'b1;
    logic       strobe_flag;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    strobe_port u_strobe_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .strobe_in(strobe_in), .cfg_latch_en(cfg_latch_en),
        .cfg_rise_edge(cfg_rise_edge), .strobe_flag(strobe_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: behavioural state, strobe history kept in a queue
    int   m_dir, m_out, m_snap, m_flag;
    bit   hist[$];

    function automatic int model_read(input logic [3:0] a);
        int v;
        v = 0;
        if (a == 4'h1 || a == 4'hF) begin
            for (int i = 0; i < 8; i++) begin
                if (m_dir[i])          v[i] = m_out[i];
                else if (cfg_latch_en) v[i] = m_snap[i];
                else                   v[i] = pin_in[i];
            end
        end else if (a == 4'h3) begin
            v = m_dir;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = 0; m_out = 0; m_snap = 0; m_flag = 0;
            hist.delete();
            hist.push_front(1'b0);
            hist.push_front(1'b0);
        end else begin
            bit active;
            active = cfg_rise_edge ? (hist[0] && !hist[1]) : (!hist[0] && hist[1]);
            if (active) begin
                m_flag = 1;
                if (cfg_latch_en) m_snap = pin_in;
            end else if ((bus_rd || bus_wr) && bus_addr == 4'h1) begin
                m_flag = 0;
            end
            if (bus_wr && bus_addr == 4'h3) m_dir = bus_wdata;
            if (bus_wr && (bus_addr == 4'h1 || bus_addr == 4'hF)) m_out = bus_wdata;
            hist.push_front(strobe_in);
            void'(hist.pop_back());
            #2;
            chk("MODEL oe", pin_oe, m_dir[7:0]);
            chk("MODEL out", pin_out, m_out[7:0] & m_dir[7:0]);
            chk("MODEL flag", {7'd0, strobe_flag}, m_flag[7:0]);
            chk("MODEL rdata", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a);
        bus_addr = a; bus_rd = 1'b1;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, input string tag, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 out", pin_out, 8'h00);
        chk("R1 flag", {7'd0, strobe_flag}, 8'h00);
        peek(4'h1, "R1 live read", 8'hA5);

        // R2 direction
        wr(4'h3, 8'hF0);
        chk("R2 oe", pin_oe, 8'hF0);
        peek(4'h3, "R2 dir readback", 8'hF0);

        // R3 output register through the quiet alias
        wr(4'hF, 8'h3C);
        chk("R3 out masked", pin_out, 8'h30);

        // R4 mixed readback, live input bits
        pin_in = 8'h0F;
        peek(4'h1, "R4 mixed read", 8'h3F);
        pin_in = 8'h06;
        peek(4'hF, "R4 live follows", 8'h36);

        // R3 stored input bits surface when made outputs
        wr(4'h3, 8'hFF);
        chk("R3 stored bits", pin_out, 8'h3C);
        wr(4'h3, 8'hF0);

        // R5 / R6 rising capture
        cfg_latch_en = 1'b1;
        pin_in = 8'h05;
        strobe_in = 1'b1;
        tick();
        chk("R5 not yet", {7'd0, strobe_flag}, 8'h00);
        tick();
        chk("R5 flag set", {7'd0, strobe_flag}, 8'h01);
        pin_in = 8'h0A;
        peek(4'hF, "R6 snapshot", 8'h35);

        // R7 alias keeps, handshake clears
        rd(4'hF);
        chk("R7 alias keeps", {7'd0, strobe_flag}, 8'h01);
        rd(4'h1);
        chk("R7 hs clears", {7'd0, strobe_flag}, 8'h00);

        // R8 inactive direction ignored
        pin_in = 8'h0C;
        strobe_in = 1'b0;
        repeat (3) tick();
        chk("R8 fall ignored", {7'd0, strobe_flag}, 8'h00);
        peek(4'h1, "R6 snapshot held", 8'h35);
        cfg_rise_edge = 1'b0;
        strobe_in = 1'b1;
        repeat (3) tick();
        chk("R8 rise ignored", {7'd0, strobe_flag}, 8'h00);
        pin_in = 8'h09;
        strobe_in = 1'b0;
        tick(); tick();
        chk("R8 fall active", {7'd0, strobe_flag}, 8'h01);
        peek(4'hF, "R8 fall capture", 8'h39);

        // R7 handshake write clears and writes
        wr(4'h1, 8'h50);
        chk("R7 write clears", {7'd0, strobe_flag}, 8'h00);
        chk("R7 write data", pin_out, 8'h50);

        // R9 event and clear on the same edge
        strobe_in = 1'b1;
        repeat (3) tick();
        pin_in = 8'h03;
        strobe_in = 1'b0;
        tick();
        rd(4'h1);
        chk("R9 set wins", {7'd0, strobe_flag}, 8'h01);
        peek(4'h1, "R9 capture", 8'h53);

        // R10 latching off: flag sets, snapshot kept
        cfg_latch_en = 1'b0;
        rd(4'h1);
        chk("R10 cleared", {7'd0, strobe_flag}, 8'h00);
        pin_in = 8'h0E;
        strobe_in = 1'b1;
        repeat (3) tick();
        strobe_in = 1'b0;
        tick(); tick();
        chk("R10 flag sets", {7'd0, strobe_flag}, 8'h01);
        peek(4'h1, "R10 live read", 8'h5E);
        cfg_latch_en = 1'b1;
        peek(4'h1, "R10 old snapshot", 8'h53);

        repeat (3) tick();
        finish_run();
    end

endmodule